// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8-bit controller's multiplexed external memory bus. One strobe is the active-high address strobe, which tells an external latch when to capture the low address byte. The other is the active-low code read strobe, which enables external program memory onto the bus. The block runs its own 12-phase machine-cycle counter from the oscillator clock. At each machine-cycle boundary it samples what the coming cycle will do: whether an external code fetch is wanted, whether the cycle moves data to or from external data memory, and whether it reads a constant table from code space. It also samples the strap and the mode flag that decide whether code comes from outside.

A control bit written through the special function register port can quiet the address strobe. While the bit is set, the strobe only pulses during data-move and code-table cycles. At all other times it rests high on a weak pull-up, which the block reports through a separate drive-enable output. The quieting bit has no effect whenever code is executed from external memory, because the external latch still needs the address there.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after it rises, `addr_strobe` is 0, `addr_strobe_drv` is 1, `code_rd_n` is 1 and the quiet bit is 0.
- R2: A machine cycle is 12 clocks, with phases numbered 0 to 11. When the address strobe is active, it is driven high in phases 0, 1, 6 and 7 and low in all other phases, giving two pulses per cycle.
- R3: In a cycle with an external code fetch and no external data access, `code_rd_n` is 0 in phases 3, 4, 9 and 10 and 1 elsewhere. Each of these pulses starts only after the address strobe has been low for at least one clock.
- R4: A cycle counts as external when `ext_strap_n` is 0 or `ext_exec` is 1. A `fetch_req` in a cycle that is not external leaves `code_rd_n` at 1 for the whole cycle.
- R5: In a cycle with `xdata_cyc` set, `code_rd_n` stays 1 for all 12 phases, even when a fetch is requested.
- R6: A write with `sfr_we` set and `sfr_addr` equal to 8EH loads bit 0 of `sfr_wdata` into the quiet bit. The other data bits, and writes to any other address, leave the quiet bit unchanged.
- R7: In a cycle where the quiet bit is 1, the cycle is not external, and neither `xdata_cyc` nor `ctab_cyc` is set, `addr_strobe` is 1 and `addr_strobe_drv` is 0 for all 12 phases.
- R8: In a cycle where the quiet bit is 1 and `xdata_cyc` or `ctab_cyc` is set, the address strobe pulses as in R2, with `addr_strobe_drv` at 1.
- R9: In an external cycle, the quiet bit has no effect: the address strobe pulses as in R2, with `addr_strobe_drv` at 1.
- R10: The cycle inputs and the quiet bit are sampled on the clock edge that leaves phase 11. Changes made at any other time do not affect the cycle that is running.
- R11: `addr_strobe` at 1 and `code_rd_n` at 0 never happen in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_strap_n | input | 1 | External-access strap; 0 sends all code fetches off chip |
| ext_exec | input | 1 | External execution mode flag |
| fetch_req | input | 1 | The coming cycle fetches code |
| xdata_cyc | input | 1 | The coming cycle accesses external data memory |
| ctab_cyc | input | 1 | The coming cycle reads a code-space table |
| sfr_we | input | 1 | Special function register write strobe |
| sfr_addr | input | 8 | Special function register address |
| sfr_wdata | input | 8 | Special function register write data |
| addr_strobe | output | 1 | Address latch strobe, active high |
| addr_strobe_drv | output | 1 | 1 = strobe actively driven, 0 = held by the weak pull-up |
| code_rd_n | output | 1 | External code read strobe, active low |

## Verification
The bench sweeps all 32 combinations of the strap, the mode flag and the three cycle requests, once with the quiet bit clear and once with it set. It checks every phase of every cycle. Halfway through each cycle it inverts all the inputs. A design that samples the cycle inputs at the wrong time therefore shows wrong strobe widths in the second half of the cycle. A design that lets the quiet bit override external execution, or that forgets the data-move and table-read exceptions, leaves the strobe flat where pulses are expected. A design that keeps the read pulses during external data cycles drives `code_rd_n` low in a cycle where it must stay high. Writes with other addresses and with cleared bit 0 show up as strobe pulses that appear or vanish in the following cycle.

// File: rtl/bstrb_pkg.sv
// Shared types for the external bus strobe generator.
// Assumes: one configuration word per machine cycle, captured at the cycle boundary.
package bstrb_pkg;

    // Per-cycle configuration, held constant for all phases of one machine cycle.
    typedef struct packed {
        logic ext_mode;   // code is executed from external memory
        logic fetch;      // a code fetch is requested
        logic xdata;      // the cycle accesses external data memory
        logic ctab;       // the cycle reads a code-space table
        logic quiet;      // the address-strobe quiet bit, as sampled
    } cyc_cfg_t;

endpackage

// File: rtl/bstrb_phase_ctr.sv
// Machine-cycle phase counter: counts 0 .. PHASES-1 and wraps.
// Resets to the last phase, so the first edge after reset opens a full cycle.
// Assumes: PHASES >= 2.
module bstrb_phase_ctr #(
    parameter int PHASES = 12,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic [PW-1:0] phase_nxt,
    output logic          last
);

    // Flags the final phase and computes the following phase.
    always_comb begin
        last      = (phase == PW'(PHASES - 1));
        phase_nxt = last ? '0 : phase + PW'(1);
    end

    // Advances the phase by one on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PW'(PHASES - 1);
        else        phase <= phase_nxt;
    end

    a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PW'(PHASES));

endmodule

// File: rtl/bstrb_sfr_bit.sv
// Holds one control bit that is written through the special function register port.
// Assumes: only bit BIT at address ADDR is used; every other write is ignored.
module bstrb_sfr_bit #(
    parameter int          AW   = 8,
    parameter logic [AW-1:0] ADDR = 8'h8E,
    parameter int          DW   = 8,
    parameter int          BIT  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          q
);

    // Loads the selected data bit on a write that hits ADDR.
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= 1'b0;
        else if (we && addr == ADDR) q <= wdata[BIT];
    end

    a_r6_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != ADDR) |=> $stable(q));

endmodule

// File: rtl/bstrb_cycle_cfg.sv
// Captures the per-cycle requests and the quiet bit at the machine-cycle boundary.
// Assumes: `last` is high during the final phase of each machine cycle.
module bstrb_cycle_cfg
    import bstrb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     last,
    input  logic     strap_n,
    input  logic     ext_exec,
    input  logic     fetch_req,
    input  logic     xdata_req,
    input  logic     ctab_req,
    input  logic     quiet_bit,
    output cyc_cfg_t cfg,
    output cyc_cfg_t cfg_nxt
);

    // Builds the configuration that the coming cycle will use.
    always_comb begin
        cfg_nxt = cfg;
        if (last) begin
            cfg_nxt.ext_mode = !strap_n || ext_exec;
            cfg_nxt.fetch    = fetch_req;
            cfg_nxt.xdata    = xdata_req;
            cfg_nxt.ctab     = ctab_req;
            cfg_nxt.quiet    = quiet_bit;
        end
    end

    // Holds the configuration for the whole machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else        cfg <= cfg_nxt;
    end

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(cfg));

endmodule

// File: rtl/bstrb_strobe_out.sv
// Registered strobe outputs. Each output is computed from the phase and
// configuration that become current on the same edge, so the outputs line up
// with the phase register.
// Assumes: each half-cycle holds the strobe window first, then a gap of at
// least one phase, then the read window (RD_START > ALE_W).
module bstrb_strobe_out
    import bstrb_pkg::*;
#(
    parameter int PHASES   = 12,
    parameter int PW       = $clog2(PHASES),
    parameter int ALE_W    = 2,
    parameter int RD_START = 3,
    parameter int RD_W     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase_nxt,
    input  cyc_cfg_t      cfg_nxt,
    output logic          strobe,
    output logic          strobe_drv,
    output logic          rd_n
);

    localparam int HALF = PHASES / 2;

    logic [PW-1:0] sub;
    logic          ale_win, rd_win, ale_on, rd_on;

    // Finds the position inside the half cycle and decides which strobes are enabled.
    always_comb begin
        sub     = (phase_nxt >= PW'(HALF)) ? phase_nxt - PW'(HALF) : phase_nxt;
        ale_win = (sub < PW'(ALE_W));
        rd_win  = (sub >= PW'(RD_START)) && (sub < PW'(RD_START + RD_W));
        ale_on  = !cfg_nxt.quiet || cfg_nxt.ext_mode || cfg_nxt.xdata || cfg_nxt.ctab;
        rd_on   = cfg_nxt.fetch && cfg_nxt.ext_mode && !cfg_nxt.xdata;
    end

    // Registers the strobes so the pins are free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe     <= 1'b0;
            strobe_drv <= 1'b1;
            rd_n       <= 1'b1;
        end else begin
            strobe     <= ale_on ? ale_win : 1'b1;
            strobe_drv <= ale_on;
            rd_n       <= !(rd_on && rd_win);
        end
    end

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !strobe);
    a_r7_weak_means_high: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_drv |-> strobe);
    a_r3_read_after_strobe_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(!strobe));

endmodule

// File: rtl/bus_strobe_gen.sv
// External bus strobe generator: the address latch strobe and the external
// code read strobe, timed from a 12-phase machine cycle.
// Assumes: the cycle requests are valid during the last phase of the cycle
// before the one they describe; synchronous active-low reset.
module bus_strobe_gen #(
    parameter int          PHASES   = 12,
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] QUIET_ADDR = 8'h8E,
    parameter int          QUIET_BIT  = 0,
    parameter int          ALE_W    = 2,
    parameter int          RD_START = 3,
    parameter int          RD_W     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_strap_n,
    input  logic          ext_exec,
    input  logic          fetch_req,
    input  logic          xdata_cyc,
    input  logic          ctab_cyc,
    input  logic          sfr_we,
    input  logic [AW-1:0] sfr_addr,
    input  logic [DW-1:0] sfr_wdata,
    output logic          addr_strobe,
    output logic          addr_strobe_drv,
    output logic          code_rd_n
);
    import bstrb_pkg::*;

    localparam int PW   = $clog2(PHASES);
    localparam int HALF = PHASES / 2;

    logic [PW-1:0] phase, phase_nxt;
    logic          last, quiet_q;
    cyc_cfg_t      cfg, cfg_nxt;

    bstrb_phase_ctr #(.PHASES(PHASES), .PW(PW)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .phase_nxt(phase_nxt), .last(last)
    );

    bstrb_sfr_bit #(.AW(AW), .ADDR(QUIET_ADDR), .DW(DW), .BIT(QUIET_BIT)) u_quiet (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata), .q(quiet_q)
    );

    bstrb_cycle_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .last(last),
        .strap_n(ext_strap_n), .ext_exec(ext_exec), .fetch_req(fetch_req),
        .xdata_req(xdata_cyc), .ctab_req(ctab_cyc), .quiet_bit(quiet_q),
        .cfg(cfg), .cfg_nxt(cfg_nxt)
    );

    bstrb_strobe_out #(.PHASES(PHASES), .PW(PW), .ALE_W(ALE_W),
                       .RD_START(RD_START), .RD_W(RD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .phase_nxt(phase_nxt), .cfg_nxt(cfg_nxt),
        .strobe(addr_strobe), .strobe_drv(addr_strobe_drv), .rd_n(code_rd_n)
    );

    a_r2_rise_on_half_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_strobe) |-> (phase == '0 || phase == PW'(HALF)));
    a_r5_no_read_in_xdata: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.xdata && !last) |=> code_rd_n);
    a_r9_ext_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ext_mode && !last) |=> addr_strobe_drv);

endmodule

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_strap_n = 1'b1, ext_exec = 1'b0, fetch_req = 1'b0;
    logic       xdata_cyc = 1'b0, ctab_cyc = 1'b0, sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
    logic       addr_strobe, addr_strobe_drv, code_rd_n;

    int total = 0;
    int bad = 0;
    int ph = 11;
    bit done = 1'b0;

    bus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .ext_strap_n(ext_strap_n), .ext_exec(ext_exec),
        .fetch_req(fetch_req), .xdata_cyc(xdata_cyc), .ctab_cyc(ctab_cyc),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .addr_strobe(addr_strobe), .addr_strobe_drv(addr_strobe_drv), .code_rd_n(code_rd_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Phase count according to R2: 12 phases; reset parks it at the last phase.
    always @(posedge clk) begin
        if (!rst_n) ph <= 11;
        else        ph <= (ph == 11) ? 0 : ph + 1;
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s phase=%0d actual=%b expected=%b", req, what, ph, act, exp);
        end
    endtask

    // Write the quiet register at phase 5, so the write lands well before the boundary (R10).
    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        while (ph != 5) @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    endtask

    // Run one machine cycle and check all 12 phases. The inputs are inverted at
    // phase 5 to show that only the boundary sample counts (R10).
    task automatic run_cycle(input logic s_n, input logic ex, input logic f,
                             input logic x, input logic c, input logic q, input string tag);
        bit ext, ale_on, in_ale, in_rd, exp_ale, exp_rd;
        string ta, tr;
        while (ph != 11) @(negedge clk);
        ext_strap_n = s_n; ext_exec = ex; fetch_req = f; xdata_cyc = x; ctab_cyc = c;
        ext    = !s_n || ex;                        // R4
        ale_on = !q || ext || x || c;               // R7, R8, R9
        if (tag != "")                 ta = tag;
        else if (q && !ext && !(x||c)) ta = "R7";
        else if (q && ext)             ta = "R9";
        else if (q)                    ta = "R8";
        else                           ta = "R2";
        if (tag != "")         tr = tag;
        else if (x)            tr = "R5";
        else if (f && !ext)    tr = "R4";
        else                   tr = "R3";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_ale  = (i % 6) < 2;
            in_rd   = ((i % 6) == 3) || ((i % 6) == 4);
            exp_ale = ale_on ? in_ale : 1'b1;
            exp_rd  = !(f && ext && !x && in_rd);
            chk(ta, addr_strobe, exp_ale, "addr_strobe");
            chk(ta, addr_strobe_drv, ale_on, "addr_strobe_drv");
            chk(tr, code_rd_n, exp_rd, "code_rd_n");
            chk("R11", addr_strobe & ~code_rd_n, 1'b0, "strobe overlap");
            if (i == 5) begin
                ext_strap_n = ~s_n; ext_exec = ~ex; fetch_req = ~f;
                xdata_cyc = ~x; ctab_cyc = ~c;
            end
        end
    endtask

    initial begin
        // R1: reset state, checked during reset
        repeat (3) @(negedge clk);
        chk("R1", addr_strobe, 1'b0, "addr_strobe in reset");
        chk("R1", addr_strobe_drv, 1'b1, "drv in reset");
        chk("R1", code_rd_n, 1'b1, "code_rd_n in reset");
        rst_n = 1'b1;
        // R1: the quiet bit is 0 after reset, so the first cycle pulses normally
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // Full sweep with quiet clear, then with quiet set
        for (int qv = 0; qv < 2; qv++) begin
            sfr_write(8'h8E, qv[0] ? 8'h01 : 8'h00);
            for (int v = 0; v < 32; v++)
                run_cycle(v[0], v[1], v[2], v[3], v[4], qv[0], "");
        end

        // R6: quiet is set now; data with bit 0 clear at 8EH clears it, despite the other bits
        sfr_write(8'h8E, 8'hFE);
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        // R6: bit 0 set at another address is ignored
        sfr_write(8'h8F, 8'h01);
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        sfr_write(8'h0E, 8'hFF);
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        // R6: a set at 8EH takes effect in the following cycle
        sfr_write(8'h8E, 8'h01);
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        // R10: a write in phase 11 is too late for the cycle that starts next
        while (ph != 11) @(negedge clk);
        sfr_we = 1'b1; sfr_addr = 8'h8E; sfr_wdata = 8'h00;
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        sfr_we = 1'b0;
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule